// File: doc/BRIEF.md
# Load/Store Queue with Store-to-Load Forwarding

This block keeps the memory operations of an out-of-order core in program order, next to the reorder buffer that holds their address computations. A slot is allocated for every load and every store as it is dispatched. Its effective address arrives later, when the paired address add completes, and a store's data arrives on a port of its own. The queue decides when a load may go ahead. A load waits while any older store still has an unknown address. If the youngest older store with a known address touches the same word, the load takes that store's data from the queue without a cache access. Otherwise it sends a read to the data cache and its result follows the cache response.

Stores never write the cache speculatively. A store sends its write only when it is the oldest entry and the reorder buffer signals retirement. Single entries can be squashed, and a flush clears the whole queue on misspeculation. A read still outstanding at the flush is dropped when its response returns. Two counters record the cumulative occupancy and the number of cycles spent full, for performance analysis.

Top module: `memq_forward`

## Requirements
- R1: Slots are handed out in program order: `alloc_idx` steps by one modulo DEPTH per accepted allocation, starting at 0 after reset or flush. `alloc_ready` is low while DEPTH entries are held, and an allocation offered then is ignored.
- R2: A load neither requests the cache nor returns a result while any older, unsquashed store in the queue has no resolved address.
- R3: A load whose address equals that of an older unsquashed store with resolved address and data returns that data one cycle after it is selected, with `ld_from_store`=1 and no cache read.
- R4: When several older stores match a load's address, the data of the youngest of them is returned.
- R5: Any other load issues one read (`creq_write`=0) at most one at a time. Its result appears the cycle after the cache response, with the response data and `ld_from_store`=0.
- R6: A store writes the cache (`creq_write`=1) only as the oldest entry with `retire` high, so writes reach the cache in program order and never earlier.
- R7: A squashed entry makes no cache request and returns no result. At the head, `retire` removes it without a write.
- R8: `flush` empties the queue in one cycle, so the next slot is 0. A cache response to a read issued before the flush produces no result.
- R9: `occ_total` adds the occupancy held before every clock edge. `full_total` counts the edges at which the queue held DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a slot this cycle |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_idx | output | $clog2(DEPTH) | Slot the next allocation receives |
| res_valid | input | 1 | Effective address of an entry is known |
| res_idx | input | $clog2(DEPTH) | Slot being resolved |
| res_addr | input | AW | Effective address |
| sdata_valid | input | 1 | Store data is available |
| sdata_idx | input | $clog2(DEPTH) | Store slot |
| sdata_data | input | DW | Store data |
| squash_valid | input | 1 | Squash one entry |
| squash_idx | input | $clog2(DEPTH) | Slot to squash |
| creq_valid | output | 1 | Cache request |
| creq_write | output | 1 | 1 = store write, 0 = load read |
| creq_addr | output | AW | Request address |
| creq_wdata | output | DW | Write data |
| creq_ready | input | 1 | Cache accepts the request |
| cresp_valid | input | 1 | Read response |
| cresp_data | input | DW | Read data |
| ld_valid | output | 1 | Load result valid |
| ld_idx | output | $clog2(DEPTH) | Slot of the completing load |
| ld_data | output | DW | Load value |
| ld_from_store | output | 1 | Value came from a queued store |
| retire | input | 1 | Reorder buffer retires the oldest entry |
| flush | input | 1 | Discard every entry |
| occ_total | output | CNTW | Cumulative occupancy |
| full_total | output | CNTW | Cycles spent full |

## Verification
The assertions take for granted that the cache returns a response only while a read is outstanding. They also assume that `res_idx`, `sdata_idx` and `squash_idx` name live slots. The stimulus keeps to this in two ways. The cache model answers each accepted read exactly once, after a latency of one to four cycles, or longer in the flush case. Every resolve, data or squash command targets a slot recorded at allocation. Squashes are issued before any address of the batch is resolved, and `retire` is raised only once all surviving loads have returned. The head is therefore always eligible when it is retired.

// File: rtl/memq_pkg.sv
// Shared types for the memory-operation queue.
// Assumes: nothing; holds only per-entry status flags.
package memq_pkg;
    typedef struct packed {
        logic vld;      // entry allocated
        logic is_st;    // store (1) or load (0)
        logic addr_ok;  // effective address resolved
        logic data_ok;  // store data present
        logic issued;   // access started
        logic done;     // access finished, value available
        logic sq;       // squashed, to be ignored
    } memq_flags_t;
endpackage

// File: rtl/memq_age_scan.sv
// Age-ordered scan over the queue: selects the oldest load that may
// execute and the youngest older store whose address matches it.
// Assumes: DEPTH is a power of two; slots head..head+count-1 are live.
module memq_age_scan
    import memq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [IW-1:0] head,
    input  logic [IW:0]   count,
    input  memq_flags_t   flags [DEPTH],
    input  logic [AW-1:0] addr  [DEPTH],
    output logic          pick_ok,
    output logic [IW-1:0] pick_idx,
    output logic          hit,
    output logic [IW-1:0] hit_idx,
    output logic          hit_ready
);
    logic          blocked;
    int            pick_k;
    logic [IW-1:0] idx;
    logic [IW-1:0] jdx;

    // Oldest ready load; stop at the first older store with unknown address.
    always_comb begin
        pick_ok  = 1'b0;
        pick_idx = '0;
        pick_k   = 0;
        blocked  = 1'b0;
        idx      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = IW'(int'(head) + k);
            if (k < int'(count) && !pick_ok && !blocked &&
                flags[idx].vld && !flags[idx].sq) begin
                if (flags[idx].is_st) begin
                    if (!flags[idx].addr_ok) blocked = 1'b1;
                end else if (flags[idx].addr_ok && !flags[idx].issued &&
                             !flags[idx].done) begin
                    pick_ok  = 1'b1;
                    pick_idx = idx;
                    pick_k   = k;
                end
            end
        end
    end

    // Youngest older store with the same address; later matches override.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        jdx     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            jdx = IW'(int'(head) + k);
            if (pick_ok && k < pick_k && flags[jdx].vld && !flags[jdx].sq &&
                flags[jdx].is_st && flags[jdx].addr_ok &&
                addr[jdx] == addr[pick_idx]) begin
                hit     = 1'b1;
                hit_idx = jdx;
            end
        end
    end

    assign hit_ready = flags[hit_idx].data_ok;
endmodule

// File: rtl/memq_occ_stats.sv
// Occupancy statistics: accumulates occupancy per cycle and counts
// cycles spent at capacity.
// Assumes: count never exceeds DEPTH.
module memq_occ_stats #(
    parameter int DEPTH = 8,
    parameter int CNTW  = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW:0]     count,
    output logic [CNTW-1:0] occ_total,
    output logic [CNTW-1:0] full_total
);
    // Add the current occupancy and note full cycles at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_total  <= '0;
            full_total <= '0;
        end else begin
            occ_total <= occ_total + CNTW'(count);
            if (count == (IW+1)'(DEPTH)) full_total <= full_total + 1'b1;
        end
    end

    // R9: the full counter only moves after a cycle at capacity.
    assert_full_tally_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full_total != $past(full_total)) |-> ($past(count) == (IW+1)'(DEPTH)));
endmodule

// File: rtl/memq_forward.sv
// Load/store queue with store-to-load forwarding.
// Holds memory operations in program order, issues loads when no older
// store address is unknown, forwards from the youngest matching older
// store, and writes stores to the cache only at retirement.
// Assumes: DEPTH is a power of two; the cache answers each accepted read
// once and in order; index inputs name live slots.
module memq_forward
    import memq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNTW  = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    input  logic            alloc_is_store,
    output logic            alloc_ready,
    output logic [IW-1:0]   alloc_idx,
    input  logic            res_valid,
    input  logic [IW-1:0]   res_idx,
    input  logic [AW-1:0]   res_addr,
    input  logic            sdata_valid,
    input  logic [IW-1:0]   sdata_idx,
    input  logic [DW-1:0]   sdata_data,
    input  logic            squash_valid,
    input  logic [IW-1:0]   squash_idx,
    output logic            creq_valid,
    output logic            creq_write,
    output logic [AW-1:0]   creq_addr,
    output logic [DW-1:0]   creq_wdata,
    input  logic            creq_ready,
    input  logic            cresp_valid,
    input  logic [DW-1:0]   cresp_data,
    output logic            ld_valid,
    output logic [IW-1:0]   ld_idx,
    output logic [DW-1:0]   ld_data,
    output logic            ld_from_store,
    input  logic            retire,
    input  logic            flush,
    output logic [CNTW-1:0] occ_total,
    output logic [CNTW-1:0] full_total
);
    memq_flags_t   flags_q [DEPTH];
    logic [AW-1:0] addr_q  [DEPTH];
    logic [DW-1:0] data_q  [DEPTH];
    logic [IW-1:0] head_q, tail_q, pend_idx_q, ld_idx_q;
    logic [IW:0]   count_q;
    logic          pend_q, drop_q;
    logic          ld_valid_q, ld_fwd_q;
    logic [DW-1:0] ld_data_q;

    logic          pick_ok, hit, hit_ready;
    logic [IW-1:0] pick_idx, hit_idx;
    logic          full, head_live, st_ready, want_store, want_load;
    logic          cresp_take, fwd_go, push, pop;
    memq_flags_t   hf;

    memq_age_scan #(.DEPTH(DEPTH), .AW(AW)) u_scan (
        .head(head_q), .count(count_q), .flags(flags_q), .addr(addr_q),
        .pick_ok(pick_ok), .pick_idx(pick_idx),
        .hit(hit), .hit_idx(hit_idx), .hit_ready(hit_ready)
    );

    memq_occ_stats #(.DEPTH(DEPTH), .CNTW(CNTW)) u_stats (
        .clk(clk), .rst_n(rst_n), .count(count_q),
        .occ_total(occ_total), .full_total(full_total)
    );

    // Issue decisions: store retirement wins the cache port over loads.
    always_comb begin
        full       = (count_q == (IW+1)'(DEPTH));
        hf         = flags_q[head_q];
        head_live  = (count_q != '0);
        st_ready   = head_live && hf.is_st && !hf.sq && hf.addr_ok && hf.data_ok;
        want_store = retire && st_ready;
        cresp_take = cresp_valid && pend_q;
        fwd_go     = pick_ok && hit && hit_ready && !cresp_take;
        want_load  = pick_ok && !hit && !pend_q && !want_store;
        push       = alloc_valid && !full;
        pop        = retire && head_live &&
                     ((hf.sq && !(pend_q && pend_idx_q == head_q)) ||
                      (!hf.is_st && hf.done) ||
                      (want_store && creq_ready));
    end

    assign alloc_ready   = !full;
    assign alloc_idx     = tail_q;
    assign creq_valid    = want_store || want_load;
    assign creq_write    = want_store;
    assign creq_addr     = want_store ? addr_q[head_q] : addr_q[pick_idx];
    assign creq_wdata    = data_q[head_q];
    assign ld_valid      = ld_valid_q;
    assign ld_idx        = ld_idx_q;
    assign ld_data       = ld_data_q;
    assign ld_from_store = ld_fwd_q;

    // Queue state: allocation, resolution, issue, completion and removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                flags_q[i] <= '0;
                addr_q[i]  <= '0;
                data_q[i]  <= '0;
            end
            head_q     <= '0;
            tail_q     <= '0;
            count_q    <= '0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            drop_q     <= 1'b0;
            ld_valid_q <= 1'b0;
            ld_idx_q   <= '0;
            ld_data_q  <= '0;
            ld_fwd_q   <= 1'b0;
        end else if (flush) begin
            for (int i = 0; i < DEPTH; i++) flags_q[i] <= '0;
            head_q     <= '0;
            tail_q     <= '0;
            count_q    <= '0;
            pend_q     <= pend_q && !cresp_valid;
            drop_q     <= pend_q && !cresp_valid;
            ld_valid_q <= 1'b0;
        end else begin
            ld_valid_q <= 1'b0;
            if (push) begin
                flags_q[tail_q]       <= '0;
                flags_q[tail_q].vld   <= 1'b1;
                flags_q[tail_q].is_st <= alloc_is_store;
                tail_q                <= tail_q + 1'b1;
            end
            if (pop) begin
                flags_q[head_q].vld <= 1'b0;
                head_q              <= head_q + 1'b1;
            end
            count_q <= count_q + (IW+1)'(push) - (IW+1)'(pop);
            if (res_valid) begin
                flags_q[res_idx].addr_ok <= 1'b1;
                addr_q[res_idx]          <= res_addr;
            end
            if (sdata_valid) begin
                flags_q[sdata_idx].data_ok <= 1'b1;
                data_q[sdata_idx]          <= sdata_data;
            end
            if (squash_valid) flags_q[squash_idx].sq <= 1'b1;
            if (fwd_go) begin
                flags_q[pick_idx].issued <= 1'b1;
                flags_q[pick_idx].done   <= 1'b1;
                ld_valid_q               <= 1'b1;
                ld_idx_q                 <= pick_idx;
                ld_data_q                <= data_q[hit_idx];
                ld_fwd_q                 <= 1'b1;
            end
            if (want_load && creq_ready) begin
                flags_q[pick_idx].issued <= 1'b1;
                pend_q                   <= 1'b1;
                pend_idx_q               <= pick_idx;
            end
            if (cresp_take) begin
                pend_q <= 1'b0;
                if (drop_q) begin
                    drop_q <= 1'b0;
                end else begin
                    flags_q[pend_idx_q].done <= 1'b1;
                    if (!flags_q[pend_idx_q].sq) begin
                        ld_valid_q <= 1'b1;
                        ld_idx_q   <= pend_idx_q;
                        ld_data_q  <= cresp_data;
                        ld_fwd_q   <= 1'b0;
                    end
                end
            end
        end
    end

    // R1: occupancy never exceeds capacity.
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= (IW+1)'(DEPTH));

    // R5: the cache answers only while a read is outstanding.
    assert_resp_expected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cresp_valid |-> pend_q);

    // R5: no second read while one is outstanding.
    assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !(creq_valid && !creq_write));

    // R3: every result follows a forward or a cache response.
    assert_result_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(fwd_go || cresp_take));

    // R6: an accepted store write removes exactly one entry.
    assert_store_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (creq_valid && creq_ready && creq_write && !flush) |=>
        (count_q == $past(count_q) + (IW+1)'($past(push)) - 1'b1));
endmodule

// File: tb/memq_forward_tb.sv
module memq_forward_tb;
    localparam int DEPTH = 8;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int CNTW  = 32;
    localparam int IW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            alloc_valid, alloc_is_store, alloc_ready;
    logic [IW-1:0]   alloc_idx;
    logic            res_valid;
    logic [IW-1:0]   res_idx;
    logic [AW-1:0]   res_addr;
    logic            sdata_valid;
    logic [IW-1:0]   sdata_idx;
    logic [DW-1:0]   sdata_data;
    logic            squash_valid;
    logic [IW-1:0]   squash_idx;
    logic            creq_valid, creq_write;
    logic [AW-1:0]   creq_addr;
    logic [DW-1:0]   creq_wdata;
    logic            creq_ready;
    logic            cresp_valid;
    logic [DW-1:0]   cresp_data;
    logic            ld_valid;
    logic [IW-1:0]   ld_idx;
    logic [DW-1:0]   ld_data;
    logic            ld_from_store;
    logic            retire, flush;
    logic [CNTW-1:0] occ_total, full_total;

    memq_forward #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CNTW(CNTW)) u_dut (.*);

    int nchecks = 0;
    int nfail = 0;
    logic [DW-1:0] mem [16];
    logic [DW-1:0] sh  [16];
    int nreads = 0, nwrites = 0, rcnt = 0, lat_override = 0, nres = 0;
    logic [DW-1:0] rdata;
    bit            got  [DEPTH];
    logic [DW-1:0] gdat [DEPTH];
    bit            gfwd [DEPTH];

    bit            b_st   [DEPTH];
    logic [AW-1:0] b_addr [DEPTH];
    logic [DW-1:0] b_data [DEPTH];
    bit            b_sq   [DEPTH];
    int            b_slot [DEPTH];
    int            b_n;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Cache stand-in: accepts every request, answers reads after a latency.
    always @(negedge clk) begin
        cresp_valid = 1'b0;
        if (rcnt > 0) begin
            rcnt--;
            if (rcnt == 0) begin
                cresp_valid = 1'b1;
                cresp_data  = rdata;
            end
        end
        if (rst_n && creq_valid && creq_ready) begin
            if (creq_write) begin
                mem[creq_addr] = creq_wdata;
                nwrites++;
            end else begin
                rdata = mem[creq_addr];
                rcnt  = (lat_override > 0) ? lat_override : 1 + int'($urandom % 4);
                nreads++;
            end
        end
    end

    // Result monitor.
    always @(negedge clk) begin
        if (rst_n && ld_valid) begin
            got[ld_idx]  = 1'b1;
            gdat[ld_idx] = ld_data;
            gfwd[ld_idx] = ld_from_store;
            nres++;
        end
    end

    function automatic logic [DW-1:0] expect_load(int k);
        logic [DW-1:0] v = sh[b_addr[k]];
        for (int j = 0; j < k; j++)
            if (!b_sq[j] && b_st[j] && b_addr[j] == b_addr[k]) v = b_data[j];
        return v;
    endfunction

    function automatic bit expect_fwd(int k);
        bit f = 1'b0;
        for (int j = 0; j < k; j++)
            if (!b_sq[j] && b_st[j] && b_addr[j] == b_addr[k]) f = 1'b1;
        return f;
    endfunction

    task automatic clear_results();
        for (int i = 0; i < DEPTH; i++) begin
            got[i] = 1'b0;
            gfwd[i] = 1'b0;
        end
    endtask

    task automatic alloc_one(bit st, output int slot);
        alloc_valid = 1'b1;
        alloc_is_store = st;
        slot = int'(alloc_idx);
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic resolve(int slot, logic [AW-1:0] a);
        res_valid = 1'b1; res_idx = IW'(slot); res_addr = a;
        tick();
        res_valid = 1'b0;
    endtask

    task automatic give_data(int slot, logic [DW-1:0] d);
        sdata_valid = 1'b1; sdata_idx = IW'(slot); sdata_data = d;
        tick();
        sdata_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
    endtask

    task automatic retire_n(int n);
        retire = 1'b1;
        repeat (n) tick();
        retire = 1'b0;
    endtask

    task automatic wait_load(int slot);
        for (int t = 0; t < 60 && !got[slot]; t++) tick();
    endtask

    task automatic run_batch();
        int acts [2*DEPTH];
        int na = 0;
        int nst = 0;
        int w0;
        b_n = 1 + int'($urandom % DEPTH);
        for (int k = 0; k < b_n; k++) begin
            b_st[k]   = bit'($urandom % 2);
            b_addr[k] = AW'($urandom % 4);
            b_data[k] = DW'($urandom);
            b_sq[k]   = ($urandom % 6) == 0;
            if (b_st[k] && !b_sq[k]) nst++;
        end
        clear_results();
        w0 = nwrites;
        for (int k = 0; k < b_n; k++) alloc_one(b_st[k], b_slot[k]);
        for (int k = 0; k < b_n; k++) begin
            if (b_sq[k]) begin
                squash_valid = 1'b1; squash_idx = IW'(b_slot[k]);
                tick();
                squash_valid = 1'b0;
            end
        end
        for (int k = 0; k < b_n; k++) begin
            acts[na++] = 2*k;
            if (b_st[k]) acts[na++] = 2*k + 1;
        end
        for (int i = na - 1; i > 0; i--) begin
            int j = int'($urandom % (i + 1));
            int t = acts[i];
            acts[i] = acts[j];
            acts[j] = t;
        end
        for (int i = 0; i < na; i++) begin
            int k = acts[i] / 2;
            if (acts[i] % 2 == 0) resolve(b_slot[k], b_addr[k]);
            else give_data(b_slot[k], b_data[k]);
            if ($urandom % 3 == 0) tick();
        end
        for (int k = 0; k < b_n; k++)
            if (!b_st[k] && !b_sq[k]) wait_load(b_slot[k]);
        for (int k = 0; k < b_n; k++) begin
            if (!b_st[k]) begin
                if (b_sq[k]) begin
                    check(!got[b_slot[k]], "R7", "squashed load result", got[b_slot[k]], 0);
                end else begin
                    check(got[b_slot[k]] && gdat[b_slot[k]] == expect_load(k), "R5",
                          "load value", gdat[b_slot[k]], expect_load(k));
                    check(gfwd[b_slot[k]] == expect_fwd(k), "R3", "forward flag",
                          gfwd[b_slot[k]], expect_fwd(k));
                end
            end
        end
        check(nwrites == w0, "R6", "writes before retire", nwrites - w0, 0);
        retire_n(b_n);
        tick();
        for (int k = 0; k < b_n; k++)
            if (b_st[k] && !b_sq[k]) sh[b_addr[k]] = b_data[k];
        check(nwrites - w0 == nst, "R7", "store writes at retire", nwrites - w0, nst);
        for (int a = 0; a < 4; a++)
            check(mem[a] == sh[a], "R6", "memory after retire", mem[a], sh[a]);
        check(alloc_ready == 1'b1, "R1", "ready when drained", alloc_ready, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchecks++;
        nfail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        int s0, s1, s2, r0, w0;
        logic [CNTW-1:0] occ_a, full_a;
        void'($urandom(32'd4242));
        alloc_valid = 0; alloc_is_store = 0; res_valid = 0; res_idx = 0; res_addr = 0;
        sdata_valid = 0; sdata_idx = 0; sdata_data = 0; squash_valid = 0; squash_idx = 0;
        creq_ready = 1; cresp_valid = 0; cresp_data = 0; retire = 0; flush = 0;
        for (int i = 0; i < 16; i++) begin
            mem[i] = DW'(i * 37 + 5);
            sh[i]  = mem[i];
        end
        clear_results();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // Reset state.
        check(alloc_ready == 1'b1 && alloc_idx == 0, "R1", "reset slot", alloc_idx, 0);
        check(ld_valid == 1'b0 && creq_valid == 1'b0, "R5", "reset idle", creq_valid, 0);
        check(occ_total == 0 && full_total == 0, "R9", "reset counters", occ_total, 0);

        // Load blocked behind a store whose address is unknown.
        clear_results();
        r0 = nreads; w0 = nwrites;
        alloc_one(1'b1, s0);
        alloc_one(1'b0, s1);
        resolve(s1, 4'd5);
        repeat (6) tick();
        check(nreads == r0 && !got[s1], "R2", "blocked load reads", nreads - r0, 0);
        resolve(s0, 4'd9);
        give_data(s0, 16'h1234);
        wait_load(s1);
        check(got[s1] && gdat[s1] == sh[5], "R5", "cache load value", gdat[s1], sh[5]);
        check(gfwd[s1] == 1'b0, "R5", "cache load flag", gfwd[s1], 0);
        check(nwrites == w0, "R6", "store held until retire", nwrites - w0, 0);
        retire_n(1);
        check(nwrites == w0 + 1 && mem[9] == 16'h1234, "R6", "store written at retire", mem[9], 16'h1234);
        retire_n(1);
        sh[9] = 16'h1234;

        // Youngest of several matching older stores wins.
        clear_results();
        alloc_one(1'b1, s0);
        alloc_one(1'b1, s1);
        alloc_one(1'b0, s2);
        resolve(s0, 4'd2); give_data(s0, 16'hAAAA);
        resolve(s1, 4'd2); give_data(s1, 16'hBBBB);
        resolve(s2, 4'd2);
        wait_load(s2);
        check(got[s2] && gdat[s2] == 16'hBBBB, "R4", "youngest store forwarded", gdat[s2], 16'hBBBB);
        check(gfwd[s2] == 1'b1, "R3", "forward flag", gfwd[s2], 1);
        w0 = nwrites;
        retire_n(3);
        tick();
        check(nwrites == w0 + 2 && mem[2] == 16'hBBBB, "R6", "ordered writes", mem[2], 16'hBBBB);
        sh[2] = 16'hBBBB;

        // Flush with a read outstanding: its response is dropped.
        clear_results();
        lat_override = 10;
        r0 = nreads;
        alloc_one(1'b0, s0);
        resolve(s0, 4'd1);
        for (int t = 0; t < 10 && nreads == r0; t++) tick();
        do_flush();
        check(alloc_idx == 0 && alloc_ready == 1'b1, "R8", "slot after flush", alloc_idx, 0);
        r0 = nres;
        repeat (14) tick();
        check(nres == r0, "R8", "dropped response", nres - r0, 0);
        lat_override = 0;

        // Occupancy, full count and backpressure.
        occ_a = occ_total;
        full_a = full_total;
        for (int k = 0; k < DEPTH; k++) begin
            check(alloc_idx == IW'(k), "R1", "slot order", alloc_idx, k);
            alloc_one(1'b1, s0);
        end
        check(alloc_ready == 1'b0, "R1", "full backpressure", alloc_ready, 0);
        alloc_valid = 1'b1;
        alloc_is_store = 1'b0;
        repeat (4) tick();
        alloc_valid = 1'b0;
        check(alloc_ready == 1'b0 && alloc_idx == 0, "R1", "ignored when full", alloc_idx, 0);
        check(occ_total - occ_a == 60, "R9", "cumulative occupancy", occ_total - occ_a, 60);
        check(full_total - full_a == 4, "R9", "full cycles", full_total - full_a, 4);
        do_flush();
        check(alloc_ready == 1'b1 && alloc_idx == 0, "R8", "empty after flush", alloc_idx, 0);

        // Random batches.
        for (int b = 0; b < 40; b++) run_batch();

        summary();
        $finish;
    end
endmodule